// File: doc/BRIEF.md
# Transfer Descriptor and Interrupt Register Bank

This block is the register bank that a processor programs to move buffers between system memory and the link-side FIFOs. On the transmit side it keeps a packet control word, a buffer start and a buffer stop address, and a running address counter. While the counter has not reached the stop address, the block requests one 64-bit word at a time from memory for the write FIFO. It also counts the quadlets it has moved so that software is told when the next packet header is due.

On the receive side it keeps a ring of three addresses: a start, a half-way stop and a full stop. Each received 64-bit word advances a write pointer. Reaching the half-way stop raises one interrupt. Reaching the full stop raises another and sends the pointer back to the start, so software can drain one half while the other fills. If words have arrived since the last half or full interrupt and reception then goes quiet for a set number of clocks, a data-waiting interrupt tells software to collect the partial half.

Five interrupt causes are latched in a status register that software clears by writing ones. A mask register selects which causes drive the single interrupt line. The memory bus protocol itself lies outside the block: it sees only a request/acknowledge pair for transmit and a one-cycle strobe for each received word.

Top module: `xfer_dma_regs`

## Requirements
- R1: Registers are selected by one address bit each, with the three low address bits zero: bit 3 control, bit 4 transmit start, bit 5 transmit stop, bit 6 receive start, bit 7 receive half stop, bit 8 receive full stop, bit 9 packet length, bit 10 status, bit 11 mask. A read returns the OR of every selected register, and returns 0 when the low three bits are not zero.
- R2: The control register holds 12 bits: bits 8..0 are the packet length in quadlets, bit 9 marks an asynchronous packet, bit 10 flags a header write during a memory transfer, and bit 11 enables reading of the link receive FIFO. The stored word is driven on `ctl_word`.
- R3: A write to the transmit start or the transmit stop register loads the transmit address counter with the written value. A write has priority over an acknowledge in the same cycle. The counter holds its value in cycles with no acknowledge and no such write.
- R4: `tx_req` is high exactly while the counter differs from the stop address. Each cycle with `tx_req` and `tx_ack` both high advances the counter by 8 bytes. An acknowledge without a request has no effect.
- R5: The acknowledge that makes the counter equal to the stop address sets status bit 0 (input done).
- R6: Each transferred word adds two quadlets to a tally. When the tally reaches the packet length register (bits 8..0; 0 disables the check), status bit 1 (header due) is set and the tally restarts from zero. A write to the transmit start register also clears the tally.
- R7: A write to the receive start register loads the receive pointer. Each `rx_beat` advances it by 8 bytes. When the advanced pointer equals the half stop address, status bit 2 is set.
- R8: When the advanced pointer equals the full stop address, status bit 3 is set and the pointer returns to the receive start address.
- R9: If a beat has arrived since the last half or full event and `IDLE_CLKS` consecutive cycles then pass without a beat, status bit 4 (data waiting) is set once.
- R10: Status bits reset to 0. Writing a 1 to a status bit clears it. An event that occurs in the same cycle as the clear leaves the bit set.
- R11: `irq` is high exactly when some status bit is set whose mask bit (register bit 11, bits 4..0) is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data for `reg_addr` |
| ctl_word | output | 12 | Stored packet control word |
| tx_req | output | 1 | Request to move the word at `tx_addr` to the write FIFO |
| tx_addr | output | AW | Transmit address counter |
| tx_ack | input | 1 | Memory has moved the requested word |
| rx_beat | input | 1 | One received word was written at `rx_addr` |
| rx_addr | output | AW | Receive ring write pointer |
| irq | output | 1 | Masked interrupt line |

## Verification
On every cycle, assertions check that the transmit counter steps by exactly one word on an accepted acknowledge and otherwise holds, that a header-due event only accompanies an accepted transfer, that the done event lands in the status register, that the ring pointer wraps to the start after a full event, that data-waiting never fires during a beat, and that a fully masked bank keeps the line low. Only the bench scenarios show the packet-length tally across several packets, reload of the counter through a stop write, the set-over-clear collision, the OR of two selected registers on read, and the exact idle count before data-waiting, because those depend on sequences that the reference model tracks cycle by cycle.

// File: rtl/xfer_dma_pkg.sv
package xfer_dma_pkg;
  localparam int CTL_W    = 12;
  localparam int LEN_W    = 9;
  localparam int QCNT_W   = LEN_W + 1;
  localparam int NIRQ     = 5;
  localparam int NREG     = 9;
  localparam int SEL_BASE = 3;
  localparam int OFF_W    = 12;

  // status bit positions
  localparam int IRQ_DONE  = 0;
  localparam int IRQ_HDR   = 1;
  localparam int IRQ_HALF  = 2;
  localparam int IRQ_FULL  = 3;
  localparam int IRQ_DWAIT = 4;

  // register slots, one per select bit above SEL_BASE
  localparam int RG_CTL      = 0;
  localparam int RG_TX_START = 1;
  localparam int RG_TX_STOP  = 2;
  localparam int RG_RX_START = 3;
  localparam int RG_RX_HALF  = 4;
  localparam int RG_RX_FULL  = 5;
  localparam int RG_PKT_LEN  = 6;
  localparam int RG_STAT     = 7;
  localparam int RG_MASK     = 8;

  function automatic logic [QCNT_W-1:0] quad_tally(input logic [QCNT_W-1:0] q);
    return q + QCNT_W'(2);
  endfunction

  function automatic logic pkt_due(input logic [QCNT_W-1:0] q,
                                   input logic [LEN_W-1:0]  len);
    return (len != '0) && (q >= {1'b0, len});
  endfunction

  function automatic logic off_aligned(input logic [OFF_W-1:0] a);
    return a[SEL_BASE-1:0] == '0;
  endfunction
endpackage

// File: rtl/xfer_tx_engine.sv
module xfer_tx_engine
  import xfer_dma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_start,
  input  logic             ld_stop,
  input  logic [AW-1:0]    wdata,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic             tx_ack,
  output logic             tx_req,
  output logic [AW-1:0]    tx_addr,
  output logic [AW-1:0]    start_q,
  output logic [AW-1:0]    stop_q,
  output logic             done_evt,
  output logic             hdr_evt
);
  localparam logic [AW-1:0] STEP = AW'(8);

  logic [AW-1:0]     cnt_q, cnt_nxt;
  logic [QCNT_W-1:0] tally_q, tally_nxt;
  logic              adv;

  assign tx_req    = cnt_q != stop_q;
  assign tx_addr   = cnt_q;
  assign adv       = tx_req & tx_ack;
  assign cnt_nxt   = cnt_q + STEP;
  assign tally_nxt = quad_tally(tally_q);
  assign done_evt  = adv && (cnt_nxt == stop_q);
  assign hdr_evt   = adv && pkt_due(tally_nxt, pkt_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      start_q <= '0;
      stop_q  <= '0;
      tally_q <= '0;
    end else begin
      if (ld_start) start_q <= wdata;
      if (ld_stop)  stop_q  <= wdata;
      if (ld_start || ld_stop) cnt_q <= wdata;
      else if (adv)            cnt_q <= cnt_nxt;
      if (ld_start) tally_q <= '0;
      else if (adv) tally_q <= hdr_evt ? '0 : tally_nxt;
    end
  end
endmodule

// File: rtl/xfer_rx_ring.sv
module xfer_rx_ring #(
  parameter int AW        = 32,
  parameter int IDLE_CLKS = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_start,
  input  logic          ld_half,
  input  logic          ld_full,
  input  logic [AW-1:0] wdata,
  input  logic          rx_beat,
  output logic [AW-1:0] rx_addr,
  output logic [AW-1:0] start_q,
  output logic [AW-1:0] half_q,
  output logic [AW-1:0] full_q,
  output logic          half_evt,
  output logic          full_evt,
  output logic          dwait_evt
);
  localparam int            IW   = (IDLE_CLKS > 2) ? $clog2(IDLE_CLKS) : 1;
  localparam logic [IW-1:0] ILIM = IW'(IDLE_CLKS - 1);
  localparam logic [AW-1:0] STEP = AW'(8);

  logic [AW-1:0] ptr_q, ptr_nxt;
  logic [IW-1:0] idle_q;
  logic          pend_q;

  assign ptr_nxt   = ptr_q + STEP;
  assign half_evt  = rx_beat && (ptr_nxt == half_q);
  assign full_evt  = rx_beat && (ptr_nxt == full_q);
  assign dwait_evt = pend_q && !rx_beat && (idle_q == ILIM);
  assign rx_addr   = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      start_q <= '0;
      half_q  <= '0;
      full_q  <= '0;
      idle_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (ld_start) start_q <= wdata;
      if (ld_half)  half_q  <= wdata;
      if (ld_full)  full_q  <= wdata;
      if (ld_start)     ptr_q <= wdata;
      else if (rx_beat) ptr_q <= full_evt ? start_q : ptr_nxt;
      if (rx_beat) begin
        idle_q <= '0;
        pend_q <= !(half_evt || full_evt);
      end else begin
        if (idle_q != ILIM) idle_q <= idle_q + IW'(1);
        if (dwait_evt)      pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/xfer_irq_bank.sv
module xfer_irq_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         clr_we,
  input  logic [N-1:0] clr_data,
  input  logic         mask_we,
  input  logic [N-1:0] mask_data,
  output logic [N-1:0] stat,
  output logic [N-1:0] mask,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stat[i] <= 1'b0;
        mask[i] <= 1'b0;
      end else begin
        if (set_vec[i])                   stat[i] <= 1'b1;
        else if (clr_we && clr_data[i])   stat[i] <= 1'b0;
        if (mask_we) mask[i] <= mask_data[i];
      end
    end
  end

  assign irq = |(stat & mask);
endmodule

// File: rtl/xfer_dma_regs.sv
module xfer_dma_regs
  import xfer_dma_pkg::*;
#(
  parameter int AW        = 32,
  parameter int IDLE_CLKS = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [OFF_W-1:0] reg_addr,
  input  logic [AW-1:0]    reg_wdata,
  output logic [AW-1:0]    reg_rdata,
  output logic [CTL_W-1:0] ctl_word,
  output logic             tx_req,
  output logic [AW-1:0]    tx_addr,
  input  logic             tx_ack,
  input  logic             rx_beat,
  output logic [AW-1:0]    rx_addr,
  output logic             irq
);
  logic [NREG-1:0]  hit, wr;
  logic [AW-1:0]    rd_val [NREG];
  logic [CTL_W-1:0] ctl_q;
  logic [LEN_W-1:0] len_q;
  logic [AW-1:0]    tx_start_q, tx_stop_q, rx_start_q, rx_half_q, rx_full_q;
  logic             done_evt, hdr_evt, half_evt, full_evt, dwait_evt;
  logic [NIRQ-1:0]  irq_set, irq_stat, irq_mask;
  logic             ld_tx_any, ld_rx_start;

  // one select bit per register above the aligned low bits
  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign hit[i] = off_aligned(reg_addr) & reg_addr[SEL_BASE+i];
    assign wr[i]  = reg_we & hit[i];
  end

  assign ld_tx_any   = wr[RG_TX_START] | wr[RG_TX_STOP];
  assign ld_rx_start = wr[RG_RX_START];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      len_q <= '0;
    end else begin
      if (wr[RG_CTL])     ctl_q <= reg_wdata[CTL_W-1:0];
      if (wr[RG_PKT_LEN]) len_q <= reg_wdata[LEN_W-1:0];
    end
  end
  assign ctl_word = ctl_q;

  xfer_tx_engine #(.AW(AW)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_start (wr[RG_TX_START]),
    .ld_stop  (wr[RG_TX_STOP]),
    .wdata    (reg_wdata),
    .pkt_len  (len_q),
    .tx_ack   (tx_ack),
    .tx_req   (tx_req),
    .tx_addr  (tx_addr),
    .start_q  (tx_start_q),
    .stop_q   (tx_stop_q),
    .done_evt (done_evt),
    .hdr_evt  (hdr_evt)
  );

  xfer_rx_ring #(.AW(AW), .IDLE_CLKS(IDLE_CLKS)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_start  (wr[RG_RX_START]),
    .ld_half   (wr[RG_RX_HALF]),
    .ld_full   (wr[RG_RX_FULL]),
    .wdata     (reg_wdata),
    .rx_beat   (rx_beat),
    .rx_addr   (rx_addr),
    .start_q   (rx_start_q),
    .half_q    (rx_half_q),
    .full_q    (rx_full_q),
    .half_evt  (half_evt),
    .full_evt  (full_evt),
    .dwait_evt (dwait_evt)
  );

  always_comb begin
    irq_set            = '0;
    irq_set[IRQ_DONE]  = done_evt;
    irq_set[IRQ_HDR]   = hdr_evt;
    irq_set[IRQ_HALF]  = half_evt;
    irq_set[IRQ_FULL]  = full_evt;
    irq_set[IRQ_DWAIT] = dwait_evt;
  end

  xfer_irq_bank #(.N(NIRQ)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vec   (irq_set),
    .clr_we    (wr[RG_STAT]),
    .clr_data  (reg_wdata[NIRQ-1:0]),
    .mask_we   (wr[RG_MASK]),
    .mask_data (reg_wdata[NIRQ-1:0]),
    .stat      (irq_stat),
    .mask      (irq_mask),
    .irq       (irq)
  );

  always_comb begin
    rd_val[RG_CTL]      = AW'(ctl_q);
    rd_val[RG_TX_START] = tx_start_q;
    rd_val[RG_TX_STOP]  = tx_stop_q;
    rd_val[RG_RX_START] = rx_start_q;
    rd_val[RG_RX_HALF]  = rx_half_q;
    rd_val[RG_RX_FULL]  = rx_full_q;
    rd_val[RG_PKT_LEN]  = AW'(len_q);
    rd_val[RG_STAT]     = AW'(irq_stat);
    rd_val[RG_MASK]     = AW'(irq_mask);
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (hit[i]) reg_rdata = reg_rdata | rd_val[i];
  end
endmodule

// File: rtl/xfer_dma_regs_chk.sv
module xfer_dma_regs_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_ack,
  input logic          tx_req,
  input logic [AW-1:0] tx_addr,
  input logic          ld_tx,
  input logic          done_evt,
  input logic          hdr_evt,
  input logic [4:0]    stat,
  input logic [4:0]    mask,
  input logic          irq,
  input logic          rx_beat,
  input logic [AW-1:0] rx_addr,
  input logic [AW-1:0] rx_start,
  input logic          ld_rx,
  input logic          full_evt,
  input logic          dwait_evt
);
  AST_TX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && tx_ack && !ld_tx) |=> tx_addr == $past(tx_addr) + AW'(8)); // R4
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ack && !ld_tx) |=> $stable(tx_addr)); // R3
  AST_DONE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> stat[0]); // R5
  AST_HDR_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_evt |-> (tx_req && tx_ack)); // R6
  AST_RX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (full_evt && !ld_rx) |=> rx_addr == $past(rx_start)); // R8
  AST_DWAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    dwait_evt |-> !rx_beat); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq); // R11
endmodule

bind xfer_dma_regs xfer_dma_regs_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_ack    (tx_ack),
  .tx_req    (tx_req),
  .tx_addr   (tx_addr),
  .ld_tx     (ld_tx_any),
  .done_evt  (done_evt),
  .hdr_evt   (hdr_evt),
  .stat      (irq_stat),
  .mask      (irq_mask),
  .irq       (irq),
  .rx_beat   (rx_beat),
  .rx_addr   (rx_addr),
  .rx_start  (rx_start_q),
  .ld_rx     (ld_rx_start),
  .full_evt  (full_evt),
  .dwait_evt (dwait_evt)
);

// File: tb/xfer_dma_regs_test.sv
module xfer_dma_regs_test;
  localparam int IDLE = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [11:0] ctl_word;
  logic        tx_req, tx_ack = 1'b0, rx_beat = 1'b0, irq;
  logic [31:0] tx_addr, rx_addr;

  int checks = 0;
  int errors = 0;
  bit live = 1'b0;

  always #10 clk = ~clk;

  xfer_dma_regs #(.AW(32), .IDLE_CLKS(IDLE)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctl_word(ctl_word),
    .tx_req(tx_req), .tx_addr(tx_addr), .tx_ack(tx_ack),
    .rx_beat(rx_beat), .rx_addr(rx_addr), .irq(irq)
  );

  // behavioural reference state
  logic [31:0] m_ctl = 0, m_txst = 0, m_txs = 0, m_txa = 0;
  logic [31:0] m_rxs = 0, m_h = 0, m_f = 0, m_rxa = 0, m_len = 0;
  logic [31:0] m_stat = 0, m_mask = 0;
  int m_q = 0, m_idle = 0;
  bit m_pend = 0;

  function automatic logic [31:0] mread(input logic [11:0] a);
    logic [31:0] r = 0;
    if (a[2:0] == 3'b000) begin
      if (a[3])  r |= m_ctl;
      if (a[4])  r |= m_txst;
      if (a[5])  r |= m_txs;
      if (a[6])  r |= m_rxs;
      if (a[7])  r |= m_h;
      if (a[8])  r |= m_f;
      if (a[9])  r |= m_len;
      if (a[10]) r |= m_stat;
      if (a[11]) r |= m_mask;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    logic [31:0] setv, clr, n;
    bit hf, fl;
    if (!rst_n) begin
      m_ctl = 0; m_txst = 0; m_txs = 0; m_txa = 0; m_rxs = 0; m_h = 0; m_f = 0;
      m_rxa = 0; m_len = 0; m_stat = 0; m_mask = 0; m_q = 0; m_idle = 0; m_pend = 0;
    end else begin
      setv = 0; clr = 0;
      if (tx_ack && m_txa != m_txs) begin
        n = m_txa + 8;
        if (n == m_txs) setv |= 1;
        m_q = (m_q + 2) % 1024;
        if (m_len != 0 && m_q >= m_len) begin setv |= 2; m_q = 0; end
        m_txa = n;
      end
      if (rx_beat) begin
        n = m_rxa + 8; hf = (n == m_h); fl = (n == m_f);
        if (hf) setv |= 4;
        if (fl) begin setv |= 8; n = m_rxs; end
        m_pend = !(hf || fl); m_idle = 0; m_rxa = n;
      end else begin
        if (m_pend && m_idle == IDLE - 1) begin setv |= 16; m_pend = 0; end
        if (m_idle < IDLE - 1) m_idle++;
      end
      if (reg_we && reg_addr[2:0] == 3'b000) begin
        if (reg_addr[3])  m_ctl = reg_wdata & 32'hFFF;
        if (reg_addr[4])  begin m_txst = reg_wdata; m_txa = reg_wdata; m_q = 0; end
        if (reg_addr[5])  begin m_txs = reg_wdata; m_txa = reg_wdata; end
        if (reg_addr[6])  begin m_rxs = reg_wdata; m_rxa = reg_wdata; end
        if (reg_addr[7])  m_h = reg_wdata;
        if (reg_addr[8])  m_f = reg_wdata;
        if (reg_addr[9])  m_len = reg_wdata & 32'h1FF;
        if (reg_addr[10]) clr = reg_wdata & 32'h1F;
        if (reg_addr[11]) m_mask = reg_wdata & 32'h1F;
      end
      m_stat = (m_stat & ~clr) | setv;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference, away from the rising edge
  always @(negedge clk) if (live) begin
    check("R4 tx_req", {31'd0, tx_req}, {31'd0, m_txa != m_txs});
    check("R3 tx_addr", tx_addr, m_txa);
    check("R7 rx_addr", rx_addr, m_rxa);
    check("R11 irq", {31'd0, irq}, {31'd0, |(m_stat & m_mask)});
    check("R2 ctl_word", {20'd0, ctl_word}, m_ctl);
    check("R1 rdata", reg_rdata, mread(reg_addr));
  end

  task automatic cyc(input bit we, input logic [11:0] a, input logic [31:0] d,
                     input bit ack, input bit beat);
    @(negedge clk); #1;
    reg_we = we; reg_addr = a; reg_wdata = d; tx_ack = ack; rx_beat = beat;
  endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] d); cyc(1, a, d, 0, 0); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) cyc(0, 12'h400, 0, 0, 0); endtask
  task automatic acks(input int n); for (int i = 0; i < n; i++) cyc(0, 12'h400, 0, 1, 0); endtask
  task automatic beats(input int n); for (int i = 0; i < n; i++) cyc(0, 12'h400, 0, 0, 1); endtask
  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    cyc(0, a, 0, 0, 0);
    @(negedge clk);
    check(tag, reg_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1; live = 1'b1;
    rd(12'h400, 32'h0, "R10 status after reset");
    check("R4 no request after reset", {31'd0, tx_req}, 32'd0);

    wr(12'h008, 32'hA05);
    rd(12'h008, 32'hA05, "R1 control readback");
    check("R2 rx fifo enable bit 11", {31'd0, ctl_word[11]}, 32'd1);
    check("R2 async bit 9", {31'd0, ctl_word[9]}, 32'd1);
    check("R2 length field", {23'd0, ctl_word[8:0]}, 32'd5);

    wr(12'h800, 32'h1F);
    wr(12'h200, 32'd4);
    wr(12'h020, 32'h1040);
    wr(12'h010, 32'h1000);
    idle(1);
    check("R3 counter loaded by start", tx_addr, 32'h1000);
    check("R4 request raised", {31'd0, tx_req}, 32'd1);

    acks(2);
    rd(12'h400, 32'h2, "R6 header due after two words");
    wr(12'h400, 32'h2);
    rd(12'h400, 32'h0, "R10 write-one clears");
    acks(3); idle(1); acks(3);
    rd(12'h400, 32'h3, "R5 done and R6 header after eight words");
    check("R4 counter at stop", tx_addr, 32'h1040);
    check("R4 request dropped", {31'd0, tx_req}, 32'd0);
    check("R11 irq with mask set", {31'd0, irq}, 32'd1);
    wr(12'h800, 32'h0); idle(1);
    check("R11 irq masked off", {31'd0, irq}, 32'd0);
    wr(12'h800, 32'h1F);
    acks(1); idle(1);
    check("R4 stray ack ignored", tx_addr, 32'h1040);

    wr(12'h400, 32'h1F);
    wr(12'h020, 32'h1100); idle(1);
    check("R3 counter loaded by stop", tx_addr, 32'h1100);
    wr(12'h010, 32'h10F8);
    acks(1);
    rd(12'h400, 32'h1, "R5 single word done");
    wr(12'h400, 32'h1F);

    rd(12'h00C, 32'h0, "R1 misaligned offset reads zero");
    rd(12'h004, 32'h0, "R1 low bit offset reads zero");
    rd(12'h018, 32'h1AFD, "R1 two selects read as OR");

    wr(12'h080, 32'h2020);
    wr(12'h100, 32'h2040);
    wr(12'h040, 32'h2000); idle(1);
    check("R7 pointer loaded", rx_addr, 32'h2000);
    beats(3);
    cyc(1, 12'h400, 32'h4, 0, 1);
    rd(12'h400, 32'h4, "R10 set wins over clear, R7 half");
    wr(12'h400, 32'h4);
    beats(4); idle(50);
    rd(12'h400, 32'h8, "R8 full without data-waiting R9");
    check("R8 pointer wrapped", rx_addr, 32'h2000);
    wr(12'h400, 32'h1F);
    beats(2); idle(10);
    rd(12'h400, 32'h0, "R9 not yet idle long enough");
    idle(40);
    rd(12'h400, 32'h10, "R9 data-waiting after idle");
    check("R7 pointer after two beats", rx_addr, 32'h2010);

    idle(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule